// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits between one 32-bit bus master and four slave regions: code flash, on-chip SRAM, a GPIO register window and a general peripheral window. When the master presents an address, the decoder finds the region that owns it. It raises one select line for that region and gives each slave its local offset. The region's upper address bits are never passed on. Addresses that belong to no region get no select line. Instead, the decoder itself answers them with a one-cycle bus error.

Transfers have two phases. The address phase is accepted in any cycle where the master requests and `m_ready` is high. In the next cycle the data phase opens, and the decoder remembers which slave owns it. For the rest of the data phase, that slave's read data and ready are passed back to the master. Ready levels from the other slaves are ignored. A slave can stretch the data phase by holding its ready low, and each slave can use a different number of wait states. A new address phase can overlap the cycle in which the current data phase completes.

Select bits are ordered by priority: bit 0 GPIO, bit 1 peripheral, bit 2 SRAM, bit 3 flash. When windows overlap, the lowest set bit wins. Region bases and sizes are parameters. The peripheral window can therefore be widened until it covers the GPIO window, and the small GPIO window still takes precedence.

Top module: `sysbus_addr_decoder`

## Requirements
- R1: An accepted address in 0x0000_0000..0x0007_FFFF sets only `sel[3]` (flash). `flash_off` always equals address bits [18:0].
- R2: An accepted address in 0x2000_0000..0x2001_FFFF sets only `sel[2]` (SRAM). `sram_off` always equals address bits [16:0].
- R3: An accepted address in 0x5000_0000..0x5000_0FFF sets only `sel[0]` (GPIO). `gpio_off` always equals address bits [11:0].
- R4: With default parameters, an accepted address in 0x4000_0000..0x4FFF_FFFF sets only `sel[1]` (peripheral). `periph_off` always equals address bits [27:0].
- R5: At most one `sel` bit is high. All of `sel` is low in any cycle without an accepted address phase, meaning any cycle where `m_req` is low or `m_ready` is low.
- R6: An accepted address outside every region, including the first byte past any region, raises no `sel` bit. In the next cycle the decoder drives `m_ready`=1, `m_err`=1 and `m_rdata`=0.
- R7: In every cycle of a data phase owned by a slave, `m_ready` and `m_rdata` equal that slave's ready and read data, and `m_err` is 0. The phase lasts until that slave's ready is high, and the other slaves' ready levels are ignored.
- R8: With the peripheral window widened to 0x4000_0000..0x5FFF_FFFF, addresses in the GPIO window still select GPIO only. Addresses from 0x5000_1000 upward select the peripheral window.
- R9: During reset, after reset, and after a data phase that completes with no new address accepted, the decoder is idle and drives `m_ready`=1, `m_err`=0, `m_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master requests an address phase |
| m_addr | input | 32 | Master byte address |
| m_ready | output | 1 | Data phase done / address can be accepted |
| m_err | output | 1 | Error response for an unmapped address |
| m_rdata | output | 32 | Read data returned to the master |
| sel | output | 4 | One-hot slave select: 0 GPIO, 1 peripheral, 2 SRAM, 3 flash |
| flash_off | output | 19 | Flash local offset |
| sram_off | output | 17 | SRAM local offset |
| gpio_off | output | 12 | GPIO register offset |
| periph_off | output | 28 | Peripheral window offset |
| gpio_rdata | input | 32 | GPIO read data |
| gpio_ready | input | 1 | GPIO ready |
| periph_rdata | input | 32 | Peripheral read data |
| periph_ready | input | 1 | Peripheral ready |
| sram_rdata | input | 32 | SRAM read data |
| sram_ready | input | 1 | SRAM ready |
| flash_rdata | input | 32 | Flash read data |
| flash_ready | input | 1 | Flash ready |

## Verification
The properties assume the master behaves like a bus master and that `rst` is high from time zero until after the first clock edge. They assume nothing about slave ready timing, so a slave may hold ready low for any length of time. The stimulus mixes addresses at every region boundary, one word past each region, unmapped holes and random offsets. It varies the request rate and gives each slave its own random ready pattern. This drives data phases from one cycle up to long stalls, including back-to-back transfers that overlap a completing data phase. A second instance, with the peripheral window widened over the GPIO window, receives the same stimulus.

// File: rtl/sysbus_dec_pkg.sv
package sysbus_dec_pkg;
  localparam int NUM_SLV  = 4;
  localparam int SLV_GPIO   = 0;
  localparam int SLV_PERIPH = 1;
  localparam int SLV_SRAM   = 2;
  localparam int SLV_FLASH  = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SLAVE = 2'd1,
    PH_ERR   = 2'd2
  } phase_e;
endpackage

// File: rtl/sysbus_region_match.sv
module sysbus_region_match #(
  parameter int          AW        = 32,
  parameter logic [31:0] BASE      = 32'h0,
  parameter int          SIZE_LOG2 = 12
) (
  input  logic [AW-1:0]        addr,
  output logic                 hit,
  output logic [SIZE_LOG2-1:0] offset
);
  localparam logic [AW-1:0] BASE_AW = BASE[AW-1:0];

  assign hit    = (addr[AW-1:SIZE_LOG2] == BASE_AW[AW-1:SIZE_LOG2]);
  assign offset = addr[SIZE_LOG2-1:0];
endmodule

// File: rtl/sysbus_sel_priority.sv
module sysbus_sel_priority #(
  parameter int N = 4
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] onehot
);
  always_comb begin
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysbus_resp_hold.sv
module sysbus_resp_hold
  import sysbus_dec_pkg::*;
#(
  parameter int DW = 32,
  parameter int N  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [N-1:0]  hit_onehot,
  input  logic [N*DW-1:0] s_rdata,
  input  logic [N-1:0]  s_ready,
  output logic          m_ready,
  output logic          m_err,
  output logic [DW-1:0] m_rdata
);
  phase_e       phase_q;
  logic [N-1:0] slot_q;
  logic [DW-1:0] slot_data [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot_data[g] = slot_q[g] ? s_rdata[g*DW +: DW] : '0;
  end

  always_comb begin
    m_rdata = '0;
    for (int i = 0; i < N; i++) m_rdata = m_rdata | slot_data[i];
  end

  always_comb begin
    unique case (phase_q)
      PH_SLAVE: m_ready = |(slot_q & s_ready);
      default:  m_ready = 1'b1;
    endcase
  end

  assign m_err = (phase_q == PH_ERR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
    end else if (m_ready) begin
      if (!accept) begin
        phase_q <= PH_IDLE;
        slot_q  <= '0;
      end else if (hit_onehot == '0) begin
        phase_q <= PH_ERR;
        slot_q  <= '0;
      end else begin
        phase_q <= PH_SLAVE;
        slot_q  <= hit_onehot;
      end
    end
  end
endmodule

// File: rtl/sysbus_addr_decoder.sv
module sysbus_addr_decoder
  import sysbus_dec_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter logic [31:0] FLASH_BASE  = 32'h0000_0000,
  parameter int          FLASH_LOG2  = 19,
  parameter logic [31:0] SRAM_BASE   = 32'h2000_0000,
  parameter int          SRAM_LOG2   = 17,
  parameter logic [31:0] GPIO_BASE   = 32'h5000_0000,
  parameter int          GPIO_LOG2   = 12,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter int          PERIPH_LOG2 = 28
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   m_req,
  input  logic [AW-1:0]          m_addr,
  output logic                   m_ready,
  output logic                   m_err,
  output logic [DW-1:0]          m_rdata,
  output logic [NUM_SLV-1:0]     sel,
  output logic [FLASH_LOG2-1:0]  flash_off,
  output logic [SRAM_LOG2-1:0]   sram_off,
  output logic [GPIO_LOG2-1:0]   gpio_off,
  output logic [PERIPH_LOG2-1:0] periph_off,
  input  logic [DW-1:0]          gpio_rdata,
  input  logic                   gpio_ready,
  input  logic [DW-1:0]          periph_rdata,
  input  logic                   periph_ready,
  input  logic [DW-1:0]          sram_rdata,
  input  logic                   sram_ready,
  input  logic [DW-1:0]          flash_rdata,
  input  logic                   flash_ready
);
  logic [NUM_SLV-1:0]    hit;
  logic [NUM_SLV-1:0]    winner;
  logic                  accept;
  logic [NUM_SLV*DW-1:0] rd_bus;
  logic [NUM_SLV-1:0]    rdy_bus;

  sysbus_region_match #(.AW(AW), .BASE(GPIO_BASE), .SIZE_LOG2(GPIO_LOG2)) u_gpio (
    .addr(m_addr), .hit(hit[SLV_GPIO]), .offset(gpio_off));
  sysbus_region_match #(.AW(AW), .BASE(PERIPH_BASE), .SIZE_LOG2(PERIPH_LOG2)) u_periph (
    .addr(m_addr), .hit(hit[SLV_PERIPH]), .offset(periph_off));
  sysbus_region_match #(.AW(AW), .BASE(SRAM_BASE), .SIZE_LOG2(SRAM_LOG2)) u_sram (
    .addr(m_addr), .hit(hit[SLV_SRAM]), .offset(sram_off));
  sysbus_region_match #(.AW(AW), .BASE(FLASH_BASE), .SIZE_LOG2(FLASH_LOG2)) u_flash (
    .addr(m_addr), .hit(hit[SLV_FLASH]), .offset(flash_off));

  sysbus_sel_priority #(.N(NUM_SLV)) u_prio (
    .hit(hit), .onehot(winner));

  assign accept = m_req & m_ready;
  assign sel    = accept ? winner : '0;

  assign rd_bus  = {flash_rdata, sram_rdata, periph_rdata, gpio_rdata};
  assign rdy_bus = {flash_ready, sram_ready, periph_ready, gpio_ready};

  sysbus_resp_hold #(.DW(DW), .N(NUM_SLV)) u_resp (
    .clk(clk), .rst(rst), .accept(accept), .hit_onehot(winner),
    .s_rdata(rd_bus), .s_ready(rdy_bus),
    .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata));
endmodule

// File: rtl/sysbus_decoder_chk.sv
module sysbus_decoder_chk #(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter logic [31:0] GPIO_BASE   = 32'h5000_0000,
  parameter int          GPIO_LOG2   = 12,
  parameter int          FLASH_LOG2  = 19,
  parameter int          SRAM_LOG2   = 17,
  parameter int          PERIPH_LOG2 = 28
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   m_req,
  input logic [AW-1:0]          m_addr,
  input logic                   m_ready,
  input logic                   m_err,
  input logic [DW-1:0]          m_rdata,
  input logic [3:0]             sel,
  input logic [FLASH_LOG2-1:0]  flash_off,
  input logic [SRAM_LOG2-1:0]   sram_off,
  input logic [DW-1:0]          gpio_rdata,
  input logic                   gpio_ready,
  input logic [DW-1:0]          sram_rdata,
  input logic                   sram_ready
);
  localparam logic [AW-1:0] GB = GPIO_BASE[AW-1:0];

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  p_sel_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !(m_req && m_ready) |-> sel == 4'b0000);

  p_err_resp_r6: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready && sel == 4'b0000) |=> (m_ready && m_err && m_rdata == '0));

  p_sram_follow_r7: assert property (@(posedge clk) disable iff (rst)
    sel[2] |=> (m_ready == sram_ready && m_rdata == sram_rdata && !m_err));

  p_gpio_follow_r7: assert property (@(posedge clk) disable iff (rst)
    sel[0] |=> (m_ready == gpio_ready && m_rdata == gpio_rdata && !m_err));

  p_gpio_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready && m_addr[AW-1:GPIO_LOG2] == GB[AW-1:GPIO_LOG2]) |-> sel == 4'b0001);

  p_flash_off_r1: assert property (@(posedge clk) disable iff (rst)
    sel[3] |-> flash_off == m_addr[FLASH_LOG2-1:0]);

  p_sram_off_r2: assert property (@(posedge clk) disable iff (rst)
    sel[2] |-> sram_off == m_addr[SRAM_LOG2-1:0]);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!m_req && m_ready) |=> (m_ready && !m_err && m_rdata == '0));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (m_ready && !m_err && m_rdata == '0));
endmodule

bind sysbus_addr_decoder sysbus_decoder_chk #(
  .AW(AW), .DW(DW), .GPIO_BASE(GPIO_BASE), .GPIO_LOG2(GPIO_LOG2),
  .FLASH_LOG2(FLASH_LOG2), .SRAM_LOG2(SRAM_LOG2), .PERIPH_LOG2(PERIPH_LOG2)
) u_chk (.*);

// File: tb/sysbus_addr_decoder_test.sv
module sysbus_addr_decoder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        m_req = 1'b0;
  logic [31:0] m_addr = 32'h0;
  logic [31:0] s_rd [4];
  logic        s_rdy [4];

  logic        rdy_a, err_a, rdy_b, err_b;
  logic [31:0] rd_a, rd_b;
  logic [3:0]  sel_a, sel_b;
  logic [18:0] fo_a, fo_b;
  logic [16:0] so_a, so_b;
  logic [11:0] go_a, go_b;
  logic [27:0] po_a;
  logic [28:0] po_b;

  int errors = 0;
  int checks = 0;
  int pend [2];

  initial begin
    for (int k = 0; k < 4; k++) begin s_rd[k] = 32'h0; s_rdy[k] = 1'b1; end
    pend[0] = -2; pend[1] = -2;
  end

  sysbus_addr_decoder uut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr),
    .m_ready(rdy_a), .m_err(err_a), .m_rdata(rd_a), .sel(sel_a),
    .flash_off(fo_a), .sram_off(so_a), .gpio_off(go_a), .periph_off(po_a),
    .gpio_rdata(s_rd[0]), .gpio_ready(s_rdy[0]),
    .periph_rdata(s_rd[1]), .periph_ready(s_rdy[1]),
    .sram_rdata(s_rd[2]), .sram_ready(s_rdy[2]),
    .flash_rdata(s_rd[3]), .flash_ready(s_rdy[3]));

  sysbus_addr_decoder #(.PERIPH_LOG2(29)) uut_ovl (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr),
    .m_ready(rdy_b), .m_err(err_b), .m_rdata(rd_b), .sel(sel_b),
    .flash_off(fo_b), .sram_off(so_b), .gpio_off(go_b), .periph_off(po_b),
    .gpio_rdata(s_rd[0]), .gpio_ready(s_rdy[0]),
    .periph_rdata(s_rd[1]), .periph_ready(s_rdy[1]),
    .sram_rdata(s_rd[2]), .sram_ready(s_rdy[2]),
    .flash_rdata(s_rd[3]), .flash_ready(s_rdy[3]));

  // -1 = unmapped; otherwise select bit index
  function automatic int region_of(logic [31:0] a, bit wide);
    if (a >= 32'h5000_0000 && a <= 32'h5000_0FFF) return 0;
    if (a >= 32'h4000_0000 && a <= (wide ? 32'h5FFF_FFFF : 32'h4FFF_FFFF)) return 1;
    if (a >= 32'h2000_0000 && a <= 32'h2001_FFFF) return 2;
    if (a <= 32'h0007_FFFF) return 3;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom % 20)
      0:  return 32'h0000_0000;
      1:  return 32'h0007_FFFC;
      2:  return 32'h0008_0000;
      3:  return 32'h2000_0000;
      4:  return 32'h2001_FFFC;
      5:  return 32'h2002_0000;
      6:  return 32'h1FFF_FFFC;
      7:  return 32'h5000_0508;
      8:  return 32'h5000_0FFC;
      9:  return 32'h5000_1000;
      10: return 32'h4FFF_FFFC;
      11: return 32'h4000_0000;
      12: return 32'h5FFF_FFFC;
      13: return 32'hFFFF_FFFC;
      14: return 32'h0000_0000 + ($urandom % 32'h0008_0000);
      15: return 32'h2000_0000 + ($urandom % 32'h0002_0000);
      16: return 32'h5000_0000 + ($urandom % 32'h0000_1000);
      17: return 32'h4000_0000 + ($urandom % 32'h1000_0000);
      18: return 32'h5000_0000 + ($urandom % 32'h1000_0000);
      default: return $urandom;
    endcase
  endfunction

  // drive at the falling edge, compare before the rising edge, then advance the model
  task automatic step(bit req, logic [31:0] addr, int pct);
    logic er [2];
    m_req  = req;
    m_addr = addr;
    for (int k = 0; k < 4; k++) begin
      s_rd[k]  = $urandom;
      s_rdy[k] = (($urandom % 100) < pct);
    end
    #2;
    for (int i = 0; i < 2; i++) begin
      logic [31:0] a_rd, e_rd;
      logic        a_rdy, a_err, e_err;
      logic [3:0]  a_sel, e_sel;
      int          reg_i;
      string       rtag, stag;
      a_rd  = (i == 0) ? rd_a : rd_b;
      a_rdy = (i == 0) ? rdy_a : rdy_b;
      a_err = (i == 0) ? err_a : err_b;
      a_sel = (i == 0) ? sel_a : sel_b;
      if (pend[i] == -2) begin er[i] = 1'b1; e_err = 1'b0; e_rd = 32'h0; rtag = "R9"; end
      else if (pend[i] == -1) begin er[i] = 1'b1; e_err = 1'b1; e_rd = 32'h0; rtag = "R6"; end
      else begin er[i] = s_rdy[pend[i]]; e_err = 1'b0; e_rd = s_rd[pend[i]]; rtag = "R7"; end
      check(rtag, "m_ready", {31'h0, a_rdy}, {31'h0, er[i]});
      check(rtag, "m_err", {31'h0, a_err}, {31'h0, e_err});
      check(rtag, "m_rdata", a_rd, e_rd);
      reg_i = region_of(addr, i == 1);
      e_sel = 4'b0000;
      if (!(req && er[i])) stag = "R5";
      else if (reg_i < 0) stag = "R6";
      else begin
        e_sel[reg_i] = 1'b1;
        if (i == 1 && addr[31:28] == 4'h5) stag = "R8";
        else if (reg_i == 0) stag = "R3";
        else if (reg_i == 1) stag = "R4";
        else if (reg_i == 2) stag = "R2";
        else stag = "R1";
      end
      check(stag, "sel", {28'h0, a_sel}, {28'h0, e_sel});
      check("R5", "sel ones", $countones(a_sel), (a_sel == 4'b0) ? 0 : 1);
    end
    check("R1", "flash_off", {13'h0, fo_a}, {13'h0, addr[18:0]});
    check("R2", "sram_off", {15'h0, so_a}, {15'h0, addr[16:0]});
    check("R3", "gpio_off", {20'h0, go_a}, {20'h0, addr[11:0]});
    check("R4", "periph_off", {4'h0, po_a}, {4'h0, addr[27:0]});
    check("R8", "periph_off wide", {3'h0, po_b}, {3'h0, addr[28:0]});
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      if (rst) pend[i] = -2;
      else if (er[i]) pend[i] = req ? region_of(addr, i == 1) : -2;
    end
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9: reset state, even with a request presented
    for (int c = 0; c < 3; c++) step(c == 2, 32'h2000_0000, 100);
    rst = 1'b0;
    step(1'b0, 32'h0, 100);
    // directed boundary sweep, all slaves ready
    for (int c = 0; c < 14; c++) begin
      logic [31:0] da;
      case (c)
        0: da = 32'h0000_0000;  1: da = 32'h0007_FFFC;  2: da = 32'h0008_0000;
        3: da = 32'h2000_0000;  4: da = 32'h2001_FFFC;  5: da = 32'h2002_0000;
        6: da = 32'h5000_0000;  7: da = 32'h5000_0508;  8: da = 32'h5000_0FFC;
        9: da = 32'h5000_1000;  10: da = 32'h4000_0000; 11: da = 32'h4FFF_FFFC;
        12: da = 32'h5FFF_FFFC; default: da = 32'hFFFF_FFFC;
      endcase
      step(1'b1, da, 100);
    end
    step(1'b0, 32'h0, 100);
    // mixed traffic with per-slave wait states
    for (int c = 0; c < 1500; c++) step(($urandom % 4) != 0, pick_addr(), 60);
    for (int c = 0; c < 600; c++)  step(1'b1, pick_addr(), 15);
    for (int c = 0; c < 300; c++)  step(($urandom % 2) == 0, pick_addr(), 90);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule